// File: doc/BRIEF.md
# Key Event Queue Interrupt Controller

This block buffers key events for a host and drives the host's active-low interrupt line. A producer, normally a key scanner, offers 8-bit event codes. Bit 7 of a code tells a press from a release, and the block stores the code unchanged in a first-in first-out queue of ten entries. Each accepted event raises a sticky key-event status bit. That bit, gated by its enable, drives the interrupt line, and a second sticky bit for a lost event has its own enable.

The host reaches the block through a small register port of four addresses. The port gives access to configuration, status, the pending-event count, and an event window whose read pops the oldest entry. The key-event status bit is write-1-to-clear, but the clear is refused while any event is still queued. An optional configuration bit makes such a refused clear release the interrupt line for a fixed number of cycles, so that a host sensing edges sees a new falling edge.

Top module: `keyq_irq_ctrl`

## Requirements
- R1: An offered code (pushValid high for one cycle) is stored whole, bit 7 included, and reads of the event window (address 3) return codes oldest first, each read removing one.
- R2: The count register (address 2, bits 3:0) reports the number of queued events and falls to zero once every event has been read.
- R3: Each accepted event sets the key-event status bit (address 1, bit 0) on the edge that stores it.
- R4: Writing 1 to address 1 bit 0 clears the key-event status bit only when the count is zero; while events remain the bit stays set.
- R5: intN is low exactly when (key status AND configuration bit 0) OR (overflow status AND configuration bit 1) holds and no release pulse is running.
- R6: With configuration bit 2 set, a refused clear made while intN is low drives intN high for PULSE_CYCLES clock cycles, after which it returns low.
- R7: With configuration bit 2 clear, a refused clear leaves intN low.
- R8: The queue holds DEPTH events (ten by default), and all ten are returned in order.
- R9: An event offered while the count equals DEPTH is dropped, leaves the count unchanged and sets the overflow status bit (address 1, bit 1), which is cleared by writing 1 to it.
- R10: Reading the event window with an empty queue returns 0x00 and leaves the count at zero.
- R11: After reset the configuration, both status bits and the count are zero and intN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Producer offers an event this cycle |
| pushCode | input | 8 | Event code; bit 7 marks press or release |
| regAddr | input | 2 | Register select: 0 config, 1 status, 2 count, 3 event window |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRd | input | 1 | Register read strobe; pops when addressing the event window |
| regRdata | output | 8 | Read data of the addressed register, combinational |
| intN | output | 1 | Active-low host interrupt |

## Verification
The assertions assume that events are offered and popped only through the strobes, and that the overflow check applies to a push made while the queue is full, even if a pop comes in the same cycle. They also assume that a host never toggles the release-pulse configuration while a pulse is running. The bench drives every strobe on the falling clock edge and holds it for exactly one cycle. It never pushes and pops in the same cycle, and it changes configuration only while no pulse is active.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_EVT  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  localparam int CFG_KEY_IEN = 0;
  localparam int CFG_OVF_IEN = 1;
  localparam int CFG_PULSE   = 2;
  localparam int STAT_KEY    = 0;
  localparam int STAT_OVF    = 1;
endpackage

// File: rtl/keyq_fifo.sv
module keyq_fifo
  import keyq_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [CODE_W-1:0] pushCode,
  output logic [CODE_W-1:0] headCode,
  output logic [CNT_W-1:0]  evtCount,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CODE_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;

  // one storage register per entry, written when the tail points at it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && tailPtr == PTR_W'(i)) slot[i] <= pushCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      evtCount <= '0;
    end else begin
      if (strobe.push) tailPtr <= (tailPtr == LAST_IDX) ? '0 : tailPtr + 1'b1;
      if (strobe.pop)  headPtr <= (headPtr == LAST_IDX) ? '0 : headPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   evtCount <= evtCount + 1'b1;
        2'b01:   evtCount <= evtCount - 1'b1;
        default: evtCount <= evtCount;
      endcase
    end
  end

  assign headCode = slot[headPtr];
  assign full     = (evtCount == FULL_CNT);
  assign empty    = (evtCount == '0);
endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl
  import keyq_pkg::*;
#(
  parameter int DEPTH        = 10,
  parameter int CODE_W       = 8,
  parameter int CNT_W        = 4,
  parameter int PULSE_CYCLES = 6250,
  parameter int PULSE_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  input  logic              regRd,
  input  logic [CODE_W-1:0] headCode,
  input  logic [CNT_W-1:0]  evtCount,
  input  logic              full,
  input  logic              empty,
  output qStrobe_t          strobe,
  output logic [7:0]        regRdata,
  output logic              intN,
  output logic              keyStat,
  output logic              ovfStat,
  output logic              keyIntEn,
  output logic              ovfIntEn,
  output logic              pulseCfg
);
  logic [PULSE_W-1:0] pulseCnt;
  logic pulseActive, irqRaw;
  logic cfgWr, statWr, keyClrReq, keyClrOk, keyRefused, pulseStart;
  logic pushAccept, pushDrop, popReq;

  assign pushAccept = pushValid && !full;
  assign pushDrop   = pushValid && full;
  assign popReq     = regRd && (regAddr == ADDR_EVT) && !empty;
  assign strobe     = '{push: pushAccept, pop: popReq};

  assign cfgWr      = regWr && (regAddr == ADDR_CFG);
  assign statWr     = regWr && (regAddr == ADDR_STAT);
  assign keyClrReq  = statWr && regWdata[STAT_KEY];
  assign keyClrOk   = keyClrReq && (evtCount == '0);
  assign keyRefused = keyClrReq && (evtCount != '0);

  assign pulseActive = (pulseCnt != '0);
  assign irqRaw      = (keyStat && keyIntEn) || (ovfStat && ovfIntEn);
  assign pulseStart  = keyRefused && pulseCfg && irqRaw && !pulseActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyIntEn <= 1'b0;
      ovfIntEn <= 1'b0;
      pulseCfg <= 1'b0;
    end else if (cfgWr) begin
      keyIntEn <= regWdata[CFG_KEY_IEN];
      ovfIntEn <= regWdata[CFG_OVF_IEN];
      pulseCfg <= regWdata[CFG_PULSE];
    end
  end

  // sticky status: a set in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStat <= 1'b0;
      ovfStat <= 1'b0;
    end else begin
      if (pushAccept)    keyStat <= 1'b1;
      else if (keyClrOk) keyStat <= 1'b0;
      if (pushDrop)      ovfStat <= 1'b1;
      else if (statWr && regWdata[STAT_OVF]) ovfStat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pulseCnt <= '0;
    else if (pulseStart)  pulseCnt <= PULSE_W'(PULSE_CYCLES);
    else if (pulseActive) pulseCnt <= pulseCnt - 1'b1;
  end

  assign intN = !(irqRaw && !pulseActive);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CFG:  regRdata = {5'b0, pulseCfg, ovfIntEn, keyIntEn};
      ADDR_STAT: regRdata = {6'b0, ovfStat, keyStat};
      ADDR_CNT:  regRdata = 8'(evtCount);
      ADDR_EVT:  regRdata = empty ? 8'h00 : 8'(headCode);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/keyq_irq_ctrl.sv
module keyq_irq_ctrl
  import keyq_pkg::*;
#(
  parameter int DEPTH        = 10,
  parameter int PULSE_CYCLES = 6250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic [7:0] pushCode,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  input  logic       regRd,
  output logic [7:0] regRdata,
  output logic       intN
);
  localparam int CODE_W  = 8;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  qStrobe_t          strobe;
  logic [CODE_W-1:0] headCode;
  logic [CNT_W-1:0]  evtCount;
  logic full, empty;
  logic keyStat, ovfStat, keyIntEn, ovfIntEn, pulseCfg;

  keyq_fifo #(.DEPTH(DEPTH), .CODE_W(CODE_W), .CNT_W(CNT_W)) i_fifo (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushCode(pushCode),
    .headCode(headCode), .evtCount(evtCount), .full(full), .empty(empty)
  );

  keyq_ctrl #(
    .DEPTH(DEPTH), .CODE_W(CODE_W), .CNT_W(CNT_W),
    .PULSE_CYCLES(PULSE_CYCLES), .PULSE_W(PULSE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRd(regRd), .headCode(headCode),
    .evtCount(evtCount), .full(full), .empty(empty), .strobe(strobe),
    .regRdata(regRdata), .intN(intN), .keyStat(keyStat), .ovfStat(ovfStat),
    .keyIntEn(keyIntEn), .ovfIntEn(ovfIntEn), .pulseCfg(pulseCfg)
  );
endmodule

// File: rtl/keyq_irq_checker.sv
module keyq_irq_checker #(
  parameter int DEPTH = 10,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic [1:0]       regAddr,
  input logic             regRd,
  input logic [7:0]       regRdata,
  input logic             intN,
  input logic [CNT_W-1:0] evtCount,
  input logic             keyStat,
  input logic             ovfStat,
  input logic             keyIntEn,
  input logic             ovfIntEn
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  a_r4_pending_holds_status: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount != '0) |-> keyStat);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    evtCount <= FULL_CNT);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount == $past(evtCount)) || (evtCount == $past(evtCount) + 1'b1) ||
    (evtCount + 1'b1 == $past(evtCount)));

  a_r9_full_push_flags: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount == FULL_CNT && pushValid) |=> ovfStat);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!keyIntEn && !ovfIntEn) |-> intN);

  a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount == '0 && regRd && regAddr == 2'd3) |-> (regRdata == 8'h00));

  a_r10_empty_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount == '0 && regRd && regAddr == 2'd3 && !pushValid) |=> (evtCount == '0));
endmodule

bind keyq_irq_ctrl keyq_irq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .regAddr(regAddr),
  .regRd(regRd), .regRdata(regRdata), .intN(intN), .evtCount(evtCount),
  .keyStat(keyStat), .ovfStat(ovfStat), .keyIntEn(keyIntEn), .ovfIntEn(ovfIntEn)
);

// File: tb/test_keyq_irq_ctrl.sv
module test_keyq_irq_ctrl;
  localparam int DEPTH = 10;
  localparam int PULSE = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 1'b0;
  logic [7:0] pushCode = '0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic       regRd = 1'b0;
  logic [7:0] regRdata;
  logic       intN;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  keyq_irq_ctrl #(.DEPTH(DEPTH), .PULSE_CYCLES(PULSE)) i_keyq_irq_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushCode(pushCode),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata), .regRd(regRd),
    .regRdata(regRdata), .intN(intN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pushEvt(input logic [7:0] code);
    @(negedge clk);
    pushValid = 1'b1; pushCode = code;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = int'(regRdata);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    chk("R11 intN after reset", int'(intN), 1);
    readReg(2'd0, v); chk("R11 config after reset", v, 0);
    readReg(2'd1, v); chk("R11 status after reset", v, 0);
    readReg(2'd2, v); chk("R11 count after reset", v, 0);
  endtask

  task automatic t_order;
    int v;
    writeReg(2'd0, 8'h01);
    pushEvt(8'h05); pushEvt(8'h85); pushEvt(8'h2A);
    readReg(2'd2, v); chk("R2 count after three pushes", v, 3);
    readReg(2'd1, v); chk("R3 key status set by push", v & 1, 1);
    chk("R5 intN low with key enable", int'(intN), 0);
    writeReg(2'd0, 8'h00);
    chk("R5 intN high with enable off", int'(intN), 1);
    writeReg(2'd0, 8'h01);
    readReg(2'd3, v); chk("R1 first event", v, 'h05);
    readReg(2'd3, v); chk("R1 release bit kept", v, 'h85);
    readReg(2'd3, v); chk("R1 third event", v, 'h2A);
    readReg(2'd2, v); chk("R2 count drained", v, 0);
    writeReg(2'd1, 8'h01);
    readReg(2'd1, v); chk("R4 clear with empty queue", v & 1, 0);
    chk("R5 intN released after clear", int'(intN), 1);
  endtask

  task automatic t_refuse;
    int v;
    pushEvt(8'h11);
    writeReg(2'd1, 8'h01);
    readReg(2'd1, v); chk("R4 clear refused while pending", v & 1, 1);
    chk("R7 intN stays low without pulse mode", int'(intN), 0);
    repeat (5) @(negedge clk);
    chk("R7 intN still low later", int'(intN), 0);
    readReg(2'd3, v); chk("R4 pending event intact", v, 'h11);
    writeReg(2'd1, 8'h01);
    readReg(2'd1, v); chk("R4 clear accepted once empty", v & 1, 0);
  endtask

  task automatic t_pulse;
    int v;
    writeReg(2'd0, 8'h05);
    pushEvt(8'h42);
    chk("R6 intN low before clear", int'(intN), 0);
    writeReg(2'd1, 8'h01);
    chk("R6 intN released on refused clear", int'(intN), 1);
    repeat (PULSE - 1) @(negedge clk);
    chk("R6 intN high at last pulse cycle", int'(intN), 1);
    @(negedge clk);
    chk("R6 intN reasserted after pulse", int'(intN), 0);
    readReg(2'd3, v); chk("R6 event survives", v, 'h42);
    writeReg(2'd1, 8'h01);
    chk("R6 intN high after real clear", int'(intN), 1);
    writeReg(2'd0, 8'h01);
  endtask

  task automatic t_overflow;
    int v;
    for (int i = 0; i < DEPTH; i++) pushEvt(8'(8'h30 + i));
    readReg(2'd2, v); chk("R8 count at capacity", v, DEPTH);
    readReg(2'd1, v); chk("R9 no overflow yet", (v >> 1) & 1, 0);
    pushEvt(8'hEE);
    readReg(2'd2, v); chk("R9 count unchanged on drop", v, DEPTH);
    readReg(2'd1, v); chk("R9 overflow flag set", (v >> 1) & 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      readReg(2'd3, v); chk("R8 entry order", v, 'h30 + i);
    end
    readReg(2'd3, v); chk("R9 dropped code absent", v, 0);
    writeReg(2'd1, 8'h03);
    readReg(2'd1, v); chk("R9 overflow cleared by write 1", v, 0);
  endtask

  task automatic t_empty_pop;
    int v;
    readReg(2'd3, v); chk("R10 empty read value", v, 0);
    readReg(2'd2, v); chk("R10 count stays zero", v, 0);
    readReg(2'd1, v); chk("R10 status untouched", v, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_refuse();
    t_pulse();
    t_overflow();
    t_empty_pop();
    summary();
  end
endmodule